// File: doc/BRIEF.md
# Straight-Line Fit Tracklet Builder

This block turns two sets of least-squares sums, one gathered over each half of a track segment, into a single 32-bit tracklet word. A one-cycle start pulse captures the channel number, both sets of sums, a 7-bit chip identifier and a 32-bit end signature. The block then merges the two halves. The second half's position sums are referenced 256 units higher, so they are shifted by that amount. It forms the fit determinant and the two numerators with one shared multiplier, over six cycles. A restoring divider, one quotient bit per cycle, gives the scaled reciprocal of the determinant, and both numerators are multiplied by it.

The same divider then forms the quality figure from the charge sum. The packed word is presented on a valid/ready output after a fixed hold.

A channel number of all ones means that no track was found. In that case the captured end signature is sent after a longer fixed hold. The end signature is also sent, with an error flag raised, when the determinant is not positive.

Top module: `trk_fit_builder`

## Requirements
- R1: While reset is asserted and after its release, busy_o, out_valid_o and err_o are low and out_data_o is zero.
- R2: A start pulse is taken only while busy_o is low, and busy_o is high in the following cycle. A start pulse while busy_o is high has no effect on the result or on the next state.
- R3: The merged sums are N=N0+N1, X=X0+X1, XX=XX0+XX1, Y=Y0+Y1+256*N1, XY=XY0+XY1+256*X1 and Q=(Q0+Q1) modulo 2^32.
- R4: Let D=N*XX-X*X, S=N*XY-X*Y and R=floor(2^34/D). Bits [31:23] of the word are bits [8:0] of floor(S*R/2^24).
- R5: Let O=XX*Y-X*XY. Bits [22:12] of the word are bits [14:4] of floor(O*R/2^24)+(channel+1)*1024.
- R6: Bits [11:7] of the word are bits [4:0] of floor(floor(Q[31:16]/N)/32). A quotient of 1024 or more wraps silently, with no flag.
- R7: Bits [6:0] of the word are the chip identifier captured at start.
- R8: A channel of 31 (5'b11111) makes the word equal to the captured end signature, with err_o low. out_valid_o then rises exactly 32 cycles after the start cycle.
- R9: For a track, out_valid_o rises no earlier than 16 cycles after the word is formed. The total latency from start is the same for every input data set.
- R10: If D is zero or negative, the word is the captured end signature and err_o is high. err_o stays high until the next accepted start clears it.
- R11: out_valid_o and out_data_o hold steady while out_ready_i is low. After a cycle with both high, busy_o and out_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a fit |
| chan_i | input | CHW (5) | Channel number; all ones means no track |
| n0_i | input | NW (8) | Hit count, first half |
| n1_i | input | NW (8) | Hit count, second half |
| x0_i | input | XW (16) | Sum of time bins, first half |
| x1_i | input | XW (16) | Sum of time bins, second half |
| xx0_i | input | XXW (24) | Sum of squared time bins, first half |
| xx1_i | input | XXW (24) | Sum of squared time bins, second half |
| y0_i | input | YW (16) | Sum of positions, first half |
| y1_i | input | YW (16) | Sum of positions, second half (256 lower reference) |
| xy0_i | input | XYW (24) | Sum of bin times position, first half |
| xy1_i | input | XYW (24) | Sum of bin times position, second half |
| q0_i | input | QW (32) | Charge sum, first half |
| q1_i | input | QW (32) | Charge sum, second half |
| chip_id_i | input | 7 | Chip identifier for the word |
| end_sig_i | input | 32 | End signature sent when there is no track |
| out_ready_i | input | 1 | Downstream accepts the word |
| busy_o | output | 1 | A fit or an output is pending |
| out_valid_o | output | 1 | out_data_o holds a word |
| out_data_o | output | 32 | Tracklet word or end signature |
| err_o | output | 1 | Determinant was not positive |

## Verification
The fit is tried on data sets with several properties. Some have small counts, where the 256 shift on the second half dominates Y and XY. Some have large sums, which exercise the full multiplier width. Some have negative slope numerators, which distinguish arithmetic from logical shifting. One has a determinant of one, which gives the largest reciprocal and a probability quotient past 1023, so a wrong field truncation shows up. Channel 31 and channel 0 separate the end-signature path from the smallest offset bias. Zero and negative determinants separate the error path from the no-track path. The channel 31 case pins down the exact 32-cycle latency. A start pulse issued during a run, and a ready held low for many cycles, show whether the captured state can be disturbed.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_MUL, S_DIV1, S_SCALE, S_DIV2, S_HOLD, S_OUT
    } fsm_e;

    localparam int SLOPE_W   = 9;
    localparam int OFS_W     = 11;
    localparam int PROB_W    = 5;
    localparam int CHIP_W    = 7;
    localparam int WORD_W    = SLOPE_W + OFS_W + PROB_W + CHIP_W;
    localparam int NT_DELAY  = 32;
    localparam int TR_DELAY  = 16;
    localparam int RECIP_EXP = 34;
    localparam int FRAC_SH   = 24;
    localparam int BIAS_SH   = 10;
    localparam int OFS_LSB   = 4;
    localparam int PROB_SH   = 5;
    localparam int QB_W      = 16;
endpackage

// File: rtl/trk_merge.sv
module trk_merge #(
    parameter int NW  = 8,
    parameter int XW  = 16,
    parameter int XXW = 24,
    parameter int YW  = 16,
    parameter int XYW = 24,
    parameter int QW  = 32,
    parameter int PW  = 96
) (
    input  logic [NW-1:0]         n0_i,
    input  logic [NW-1:0]         n1_i,
    input  logic [XW-1:0]         x0_i,
    input  logic [XW-1:0]         x1_i,
    input  logic [XXW-1:0]        xx0_i,
    input  logic [XXW-1:0]        xx1_i,
    input  logic [YW-1:0]         y0_i,
    input  logic [YW-1:0]         y1_i,
    input  logic [XYW-1:0]        xy0_i,
    input  logic [XYW-1:0]        xy1_i,
    input  logic [QW-1:0]         q0_i,
    input  logic [QW-1:0]         q1_i,
    output logic signed [PW-1:0]  n_o,
    output logic signed [PW-1:0]  x_o,
    output logic signed [PW-1:0]  xx_o,
    output logic signed [PW-1:0]  y_o,
    output logic signed [PW-1:0]  xy_o,
    output logic [trk_pkg::QB_W-1:0] qb_o
);
    localparam int SHIFT2 = 8;
    logic [QW-1:0] q_sum;

    assign n_o  = $signed(PW'(n0_i) + PW'(n1_i));
    assign x_o  = $signed(PW'(x0_i) + PW'(x1_i));
    assign xx_o = $signed(PW'(xx0_i) + PW'(xx1_i));
    assign y_o  = $signed(PW'(y0_i) + PW'(y1_i) + (PW'(n1_i) << SHIFT2));
    assign xy_o = $signed(PW'(xy0_i) + PW'(xy1_i) + (PW'(x1_i) << SHIFT2));
    assign q_sum = q0_i + q1_i;
    assign qb_o  = q_sum[QW-1 -: trk_pkg::QB_W];
endmodule

// File: rtl/trk_div.sv
module trk_div #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic          done_o,
    output logic [DW-1:0] quot_o
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW:0]   rem;
        logic [DW-1:0] quo;
        logic [DW-1:0] dvs;
    } div_t;

    div_t d, q;
    logic [DW:0] shifted;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem[DW-1:0], q.quo[DW-1]};
        if (start_i) begin
            d.run = 1'b1;
            d.rem = '0;
            d.quo = dividend_i;
            d.dvs = divisor_i;
            d.cnt = CW'(DW - 1);
        end else if (q.run) begin
            if (shifted >= {1'b0, q.dvs}) begin
                d.rem = shifted - {1'b0, q.dvs};
                d.quo = {q.quo[DW-2:0], 1'b1};
            end else begin
                d.rem = shifted;
                d.quo = {q.quo[DW-2:0], 1'b0};
            end
            if (q.cnt == '0) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.quo;
endmodule

// File: rtl/trk_fit_builder.sv
module trk_fit_builder
    import trk_pkg::*;
#(
    parameter int CHW = 5,
    parameter int NW  = 8,
    parameter int XW  = 16,
    parameter int XXW = 24,
    parameter int YW  = 16,
    parameter int XYW = 24,
    parameter int QW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [CHW-1:0] chan_i,
    input  logic [NW-1:0]  n0_i,
    input  logic [NW-1:0]  n1_i,
    input  logic [XW-1:0]  x0_i,
    input  logic [XW-1:0]  x1_i,
    input  logic [XXW-1:0] xx0_i,
    input  logic [XXW-1:0] xx1_i,
    input  logic [YW-1:0]  y0_i,
    input  logic [YW-1:0]  y1_i,
    input  logic [XYW-1:0] xy0_i,
    input  logic [XYW-1:0] xy1_i,
    input  logic [QW-1:0]  q0_i,
    input  logic [QW-1:0]  q1_i,
    input  logic [6:0]     chip_id_i,
    input  logic [31:0]    end_sig_i,
    input  logic           out_ready_i,
    output logic           busy_o,
    output logic           out_valid_o,
    output logic [31:0]    out_data_o,
    output logic           err_o
);
    localparam int DEN_W = NW + XXW + 2;
    localparam int DW    = ((DEN_W > RECIP_EXP + 1) ? DEN_W : RECIP_EXP + 1) + 1;
    localparam int PW    = 2 * DW + FRAC_SH;
    localparam int CW    = $clog2(NT_DELAY);

    typedef struct packed {
        fsm_e                 st;
        logic [2:0]           step;
        logic [CW-1:0]        cnt;
        logic signed [PW-1:0] n;
        logic signed [PW-1:0] x;
        logic signed [PW-1:0] xx;
        logic signed [PW-1:0] y;
        logic signed [PW-1:0] xy;
        logic signed [PW-1:0] den;
        logic signed [PW-1:0] sl;
        logic signed [PW-1:0] of;
        logic [DW-1:0]        recip;
        logic [QB_W-1:0]      qb;
        logic [CHW-1:0]       chp1;
        logic [CHIP_W-1:0]    chip;
        logic [WORD_W-1:0]    esig;
        logic [WORD_W-1:0]    word;
        logic                 err;
    } fit_t;

    fit_t d, q;

    logic signed [PW-1:0] m_n, m_x, m_xx, m_y, m_xy;
    logic [QB_W-1:0]      m_qb;
    logic signed [PW-1:0] mul_a, mul_b, prod;
    logic signed [PW-1:0] sl_sc, of_sc, bias;
    logic [CHW-1:0]       chan_p1;
    logic                 div_go, div_done;
    logic [DW-1:0]        div_a, div_b, div_q;

    trk_merge #(
        .NW(NW), .XW(XW), .XXW(XXW), .YW(YW), .XYW(XYW), .QW(QW), .PW(PW)
    ) i_merge (
        .n0_i(n0_i), .n1_i(n1_i), .x0_i(x0_i), .x1_i(x1_i),
        .xx0_i(xx0_i), .xx1_i(xx1_i), .y0_i(y0_i), .y1_i(y1_i),
        .xy0_i(xy0_i), .xy1_i(xy1_i), .q0_i(q0_i), .q1_i(q1_i),
        .n_o(m_n), .x_o(m_x), .xx_o(m_xx), .y_o(m_y), .xy_o(m_xy), .qb_o(m_qb)
    );

    trk_div #(.DW(DW)) i_div (
        .clk(clk), .rst_n(rst_n), .start_i(div_go),
        .dividend_i(div_a), .divisor_i(div_b),
        .done_o(div_done), .quot_o(div_q)
    );

    assign chan_p1 = chan_i + 1'b1;
    assign prod    = mul_a * mul_b;
    assign sl_sc   = q.sl >>> FRAC_SH;
    assign bias    = $signed(PW'(q.chp1) << BIAS_SH);
    assign of_sc   = (q.of >>> FRAC_SH) + bias;

    always_comb begin
        d      = q;
        div_go = 1'b0;
        div_a  = '0;
        div_b  = '0;
        mul_a  = '0;
        mul_b  = '0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.n    = m_n;
                    d.x    = m_x;
                    d.xx   = m_xx;
                    d.y    = m_y;
                    d.xy   = m_xy;
                    d.qb   = m_qb;
                    d.chp1 = chan_p1;
                    d.chip = chip_id_i;
                    d.esig = end_sig_i;
                    d.err  = 1'b0;
                    d.step = '0;
                    if (chan_p1 == '0) begin
                        d.word = end_sig_i;
                        d.cnt  = CW'(NT_DELAY - 1);
                        d.st   = S_HOLD;
                    end else begin
                        d.st = S_MUL;
                    end
                end
            end
            S_MUL: begin
                case (q.step)
                    3'd0:    begin mul_a = q.n;  mul_b = q.xx; end
                    3'd1:    begin mul_a = q.x;  mul_b = q.x;  end
                    3'd2:    begin mul_a = q.n;  mul_b = q.xy; end
                    3'd3:    begin mul_a = q.x;  mul_b = q.y;  end
                    3'd4:    begin mul_a = q.xx; mul_b = q.y;  end
                    default: begin mul_a = q.x;  mul_b = q.xy; end
                endcase
                d.step = q.step + 1'b1;
                case (q.step)
                    3'd0:    d.den = prod;
                    3'd1:    d.den = q.den - prod;
                    3'd2:    d.sl  = prod;
                    3'd3:    d.sl  = q.sl - prod;
                    3'd4:    d.of  = prod;
                    default: begin
                        d.of = q.of - prod;
                        if (q.den <= 0) begin
                            d.word = q.esig;
                            d.err  = 1'b1;
                            d.cnt  = CW'(NT_DELAY - 1);
                            d.st   = S_HOLD;
                        end else begin
                            div_go = 1'b1;
                            div_a  = DW'(1) << RECIP_EXP;
                            div_b  = q.den[DW-1:0];
                            d.st   = S_DIV1;
                        end
                    end
                endcase
            end
            S_DIV1: begin
                if (div_done) begin
                    d.recip = div_q;
                    d.step  = '0;
                    d.st    = S_SCALE;
                end
            end
            S_SCALE: begin
                mul_a = (q.step == '0) ? q.sl : q.of;
                mul_b = $signed(PW'(q.recip));
                if (q.step == '0) begin
                    d.sl   = prod;
                    d.step = 3'd1;
                end else begin
                    d.of   = prod;
                    div_go = 1'b1;
                    div_a  = DW'(q.qb);
                    div_b  = q.n[DW-1:0];
                    d.st   = S_DIV2;
                end
            end
            S_DIV2: begin
                if (div_done) begin
                    d.word = {sl_sc[SLOPE_W-1:0],
                              of_sc[OFS_LSB +: OFS_W],
                              div_q[PROB_SH +: PROB_W],
                              q.chip};
                    d.cnt  = CW'(TR_DELAY - 1);
                    d.st   = S_HOLD;
                end
            end
            S_HOLD: begin
                if (q.cnt == '0) d.st = S_OUT;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: begin
                if (out_ready_i) d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st != S_IDLE);
    assign out_valid_o = (q.st == S_OUT);
    assign out_data_o  = q.word;
    assign err_o       = q.err;
endmodule

// File: rtl/trk_fit_builder_chk.sv
module trk_fit_builder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] end_sig_i,
    input logic        out_ready_i,
    input logic        busy_o,
    input logic        out_valid_o,
    input logic [31:0] out_data_o,
    input logic        err_o
);
    localparam int GAP_MIN = trk_pkg::TR_DELAY;
    logic [7:0]  gap_q;
    logic [31:0] esig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            esig_q <= '0;
        end else begin
            if (start_i && !busy_o) esig_q <= end_sig_i;
            if (!busy_o) gap_q <= '0;
            else if (!out_valid_o && gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    p_valid_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> busy_o);

    p_hold_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> gap_q >= 8'(GAP_MIN));

    p_err_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && err_o |-> out_data_o == esig_q);

    p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i |=> !busy_o && !out_valid_o);
endmodule

bind trk_fit_builder trk_fit_builder_chk i_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_sig_i(end_sig_i),
    .out_ready_i(out_ready_i), .busy_o(busy_o), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .err_o(err_o)
);

// File: tb/test_trk_fit_builder.sv
module test_trk_fit_builder;
    typedef struct packed {
        logic [4:0]  ch;
        logic [6:0]  chip;
        logic [7:0]  n0, n1;
        logic [15:0] x0, x1;
        logic [23:0] xx0, xx1;
        logic [15:0] y0, y1;
        logic [23:0] xy0, xy1;
        logic [31:0] q0, q1;
    } vec_t;

    localparam int NV = 6;
    localparam logic [31:0] ESIG = 32'h5A5A_0F3C;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  7'h11, 8'd6,   8'd6,   16'd15,   16'd51,    24'd55,     24'd451,
          16'd100,   16'd20,   24'd300,    24'd200,    32'h0040_0000, 32'h0020_0000},
        '{5'd0,  7'h2A, 8'd4,   8'd5,   16'd6,    16'd35,    24'd14,     24'd255,
          16'd50,    16'd10,   24'd80,     24'd400,    32'h0100_0000, 32'h0000_8000},
        '{5'd17, 7'h05, 8'd10,  8'd10,  16'd45,   16'd145,   24'd285,    24'd2185,
          16'd1000,  16'd900,  24'd5000,   24'd3000,   32'h1234_5678, 32'h0101_0101},
        '{5'd30, 7'h7F, 8'd100, 8'd100, 16'd5000, 16'd15000, 24'd300000, 24'd2300000,
          16'd20000, 16'd3000, 24'd100000, 24'd500000, 32'h8000_0000, 32'h7000_0000},
        '{5'd7,  7'h40, 8'd8,   8'd8,   16'd28,   16'd92,    24'd140,    24'd1076,
          16'd3000,  16'd0,    24'd10000,  24'd50,     32'hFF00_0000, 32'h0000_0000},
        '{5'd12, 7'h33, 8'd1,   8'd1,   16'd0,    16'd1,     24'd0,      24'd1,
          16'd5,     16'd7,    24'd0,      24'd9,      32'hFFFF_0000, 32'h0000_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready = 1'b0;
    vec_t cur = '0;
    logic [31:0] esig_in = ESIG;
    logic busy, valid, err;
    logic [31:0] data;

    int checks = 0;
    int errors = 0;
    int lat_track = -1;

    always #5 clk = ~clk;

    trk_fit_builder i_trk_fit_builder (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(cur.ch),
        .n0_i(cur.n0), .n1_i(cur.n1), .x0_i(cur.x0), .x1_i(cur.x1),
        .xx0_i(cur.xx0), .xx1_i(cur.xx1), .y0_i(cur.y0), .y1_i(cur.y1),
        .xy0_i(cur.xy0), .xy1_i(cur.xy1), .q0_i(cur.q0), .q1_i(cur.q1),
        .chip_id_i(cur.chip), .end_sig_i(esig_in), .out_ready_i(ready),
        .busy_o(busy), .out_valid_o(valid), .out_data_o(data), .err_o(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word from the R3..R8/R10 formulas
    function automatic logic [31:0] model(input vec_t v, input logic [31:0] es, output logic e);
        logic signed [95:0] n, x, xx, y, xy, den, sn, on, rc, sl, of, bias;
        logic [31:0] qs;
        logic [15:0] qb;
        logic [15:0] pq;
        n  = 96'(v.n0) + 96'(v.n1);
        x  = 96'(v.x0) + 96'(v.x1);
        xx = 96'(v.xx0) + 96'(v.xx1);
        y  = 96'(v.y0) + 96'(v.y1) + 96'(v.n1) * 256;
        xy = 96'(v.xy0) + 96'(v.xy1) + 96'(v.x1) * 256;
        den = n * xx - x * x;
        sn  = n * xy - x * y;
        on  = xx * y - x * xy;
        e = 1'b0;
        if (v.ch == 5'd31) return es;
        if (den <= 0) begin
            e = 1'b1;
            return es;
        end
        rc   = (96'sd1 <<< 34) / den;
        sl   = (sn * rc) >>> 24;
        of   = (on * rc) >>> 24;
        bias = (96'(v.ch) + 96'd1) * 1024;
        of   = of + bias;
        qs = v.q0 + v.q1;
        qb = qs[31:16];
        pq = 16'((96'(qb) / n) >> 5);
        return {sl[8:0], of[14:4], pq[4:0], v.chip};
    endfunction

    task automatic launch(input vec_t v, input logic [31:0] es);
        @(negedge clk);
        cur = v;
        esig_in = es;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        while (!valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic accept(input string req);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        check(req, {30'd0, busy, valid}, 32'd0);
    endtask

    task automatic run_one(input vec_t v, input logic [31:0] es, input string req, output int lat);
        logic e_exp;
        logic [31:0] w_exp;
        w_exp = model(v, es, e_exp);
        launch(v, es);
        check("R2 busy after start", {31'd0, busy}, 32'd1);
        wait_valid(lat);
        check(req, data, w_exp);
        check("R10 err flag", {31'd0, err}, {31'd0, e_exp});
        accept("R11 idle after handshake");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        check("R1 reset outputs", {busy, valid, err, 29'd0}, 32'd0);
        check("R1 reset data", data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {busy, valid, err, 29'd0}, 32'd0);

        // Table walk: R3 R4 R5 R6 R7 and R9 constant latency
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], ESIG, "R3/R4/R5/R6/R7 tracklet word", lat);
            if (lat_track < 0) lat_track = lat;
            check("R9 fixed latency", 32'(lat), 32'(lat_track));
            checks++;
            if (lat < 16) begin
                errors++;
                $display("FAIL R9 latency: actual %0d expected >= 16", lat);
            end
        end

        // R8 channel 31: end signature after exactly 32 cycles
        begin
            vec_t v = VECS[0];
            v.ch = 5'd31;
            run_one(v, 32'hC0DE_1234, "R8 end signature", lat);
            check("R8 latency", 32'(lat), 32'd32);
        end

        // R10 zero determinant
        begin
            vec_t v = '{5'd2, 7'h01, 8'd1, 8'd0, 16'd3, 16'd0, 24'd9, 24'd0,
                        16'd4, 16'd0, 24'd5, 24'd0, 32'd0, 32'd0};
            run_one(v, ESIG, "R10 zero determinant", lat);
            check("R10 err set", {31'd0, err}, 32'd1);
            // negative determinant
            v = '{5'd2, 7'h01, 8'd1, 8'd1, 16'd10, 16'd0, 24'd1, 24'd0,
                  16'd4, 16'd0, 24'd5, 24'd0, 32'd0, 32'd0};
            run_one(v, 32'h0BAD_F00D, "R10 negative determinant", lat);
            // next good start clears err
            run_one(VECS[1], ESIG, "R10 err cleared word", lat);
            check("R10 err cleared", {31'd0, err}, 32'd0);
        end

        // R2 start during busy ignored; R11 long stall
        begin
            logic e_exp;
            logic [31:0] w_exp;
            w_exp = model(VECS[2], ESIG, e_exp);
            launch(VECS[2], ESIG);
            repeat (5) @(negedge clk);
            cur = VECS[3];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_valid(lat);
            check("R2 busy start ignored", data, w_exp);
            repeat (10) @(negedge clk);
            check("R11 valid held", {31'd0, valid}, 32'd1);
            check("R11 data held", data, w_exp);
            accept("R11 release");
            repeat (60) @(negedge clk);
            check("R2 no second run", {31'd0, busy}, 32'd0);
        end

        // R7 chip id passes through for another id
        begin
            vec_t v = VECS[4];
            logic e_exp;
            v.chip = 7'h00;
            run_one(v, ESIG, "R7 chip id zero", lat);
            check("R7 low bits", {25'd0, data[6:0]}, 32'd0);
            e_exp = 1'b0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule